// File: doc/BRIEF.md
# Prioritized Interrupt Vector Encoder

This block sits beside a two-wire serial bus engine and turns its seven event pulses into a single interrupt request plus a small vector code. Each pulse sets a sticky flag. The flags are gated by a writable enable mask. The vector register reports the most urgent flag that is both pending and enabled, as a 3-bit code. Software services the interrupt by reading the vector over and over until it returns zero.

Reading the vector clears the flag it reported for most events. Two events work differently: stop detected and access ready stay set until software writes a one to their bit in the status register. Two level inputs, bus busy and receive-shift full, appear in the status word so that one read shows the whole picture.

The register port is a plain synchronous port with a 2-bit address. Read data is combinational in the same cycle as `reg_rd`. The block carries no data stream, so it has no valid/ready handshake and no back-pressure rules: every access completes in the cycle it is issued.

Top module: `serial_evt_vector`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[i]` sets flag i, and the flag shows in the status word (address 1) from the next cycle. Bit positions are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as target.
- R2: The enable mask is at address 0 and uses the same bit layout in bits 6:0. Writes take effect on the next cycle. After reset the mask is 0x67, which enables target, stop, access ready, no-acknowledge and arbitration lost.
- R3: The vector at address 2 reads (i+1), where i is the lowest-numbered flag that is both pending and enabled. It reads 0 when no such flag exists. Code 1 therefore has the highest priority and code 7 the lowest.
- R4: A masked event still latches in the status word but does not contribute to the vector or to `irq`.
- R5: `irq` is high exactly when the vector would read nonzero.
- R6: A vector read that returns 1, 2, 4, 5 or 7 clears the reported flag for the next cycle, so a repeated read exposes the next pending event.
- R7: A vector read that returns 3 or 6 leaves the flag set. Those flags clear only when a one is written to status bit 2 or bit 5.
- R8: Writing ones to status bits other than 2 and 5 changes no flag.
- R9: Status bit 12 mirrors `bus_busy` and bit 11 mirrors `rx_full`. Status bits 15:13 and 10:7 read zero.
- R10: When an event pulse arrives in the same cycle as a clear of the same flag, the flag stays set.
- R11: `reg_rdata` is valid combinationally while `reg_rd` is high. Address 3 reads zero, and `reg_rdata` is zero when `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 7 | Event set pulses, one bit per event |
| bus_busy | input | 1 | Bus busy level from the engine |
| rx_full | input | 1 | Receive-shift full level from the engine |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 mask, 1 status, 2 vector |
| reg_wdata | input | 7 | Write data; only bits 6:0 are writable anywhere |
| reg_rdata | output | 16 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
A flag that latches wrongly or clears wrongly shows up on the next vector or status read. It also shows on `irq` in the cycle right after the faulty edge. Because of this, the bench compares `irq` on every cycle and compares every read against its behavioural model. A wrong priority order or a wrong read-clear set shows up as a wrong code, or as a code that repeats or is skipped, during the drain sequences that poll the vector until it reads zero.

// File: rtl/sev_pkg.sv
package sev_pkg;
  localparam int EVT_N   = 7;
  localparam int CODE_W  = $clog2(EVT_N + 1);
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 2;
  localparam int BUSY_BIT = 12;
  localparam int RXF_BIT  = 11;

  // bit index of each event: the vector code is index + 1
  localparam int EV_ARB  = 0;
  localparam int EV_NAK  = 1;
  localparam int EV_ARDY = 2;
  localparam int EV_RRDY = 3;
  localparam int EV_XRDY = 4;
  localparam int EV_STOP = 5;
  localparam int EV_TGT  = 6;

  localparam logic [EVT_N-1:0] MASK_RST = 7'h67;
  localparam logic [EVT_N-1:0] W1C_SET  = (7'd1 << EV_ARDY) | (7'd1 << EV_STOP);
  localparam logic [EVT_N-1:0] RDCLR_SET = ~W1C_SET;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK = 2'd0,
    A_STAT = 2'd1,
    A_VEC  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sev_flag_bank.sv
module sev_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[g] <= 1'b0;
      else if (set_i[g])   flags_o[g] <= 1'b1;
      else if (clr_i[g])   flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/sev_prio_enc.sv
module sev_prio_enc #(
  parameter int N      = 7,
  parameter int CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      req_i,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = CODE_W'(i + 1);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/sev_reg_port.sv
module sev_reg_port
  import sev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EVT_N-1:0]  wdata_i,
  input  logic [EVT_N-1:0]  flags_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              busy_i,
  input  logic              rxf_i,
  output logic [EVT_N-1:0]  mask_o,
  output logic [EVT_N-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_mask, wr_stat, rd_vec;
  logic [EVT_N-1:0] code_oh;
  logic [DATA_W-1:0] stat_word;

  assign wr_mask = wr_i && (addr_i == A_MASK);
  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign rd_vec  = rd_i && (addr_i == A_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_o <= MASK_RST;
    else if (wr_mask) mask_o <= wdata_i;
  end

  assign code_oh = (code_i == '0) ? '0 : (EVT_N'(1) << (code_i - CODE_W'(1)));
  assign clr_o = (wr_stat ? (wdata_i & W1C_SET) : '0)
               | (rd_vec  ? (code_oh & RDCLR_SET) : '0);

  always_comb begin
    stat_word = '0;
    stat_word[EVT_N-1:0] = flags_i;
    stat_word[BUSY_BIT]  = busy_i;
    stat_word[RXF_BIT]   = rxf_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        A_MASK:  rdata_o = DATA_W'(mask_o);
        A_STAT:  rdata_o = stat_word;
        A_VEC:   rdata_o = DATA_W'(code_i);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/serial_evt_vector.sv
module serial_evt_vector
  import sev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic              bus_busy,
  input  logic              rx_full,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [EVT_N-1:0]  reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [EVT_N-1:0]  flags_q, mask_q, clr_req, pend;
  logic [CODE_W-1:0] vec_code;

  sev_flag_bank #(.N(EVT_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .clr_i(clr_req), .flags_o(flags_q)
  );

  assign pend = flags_q & mask_q;

  sev_prio_enc #(.N(EVT_N), .CODE_W(CODE_W)) u_enc (
    .req_i(pend), .code_o(vec_code), .any_o(irq)
  );

  sev_reg_port u_port (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .flags_i(flags_q), .code_i(vec_code), .busy_i(bus_busy),
    .rxf_i(rx_full), .mask_o(mask_q), .clr_o(clr_req), .rdata_o(reg_rdata)
  );
endmodule

// File: rtl/sev_chk.sv
module sev_chk
  import sev_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [EVT_N-1:0]  evt,
  input logic [EVT_N-1:0]  flags,
  input logic [EVT_N-1:0]  mask,
  input logic [CODE_W-1:0] code,
  input logic              irq,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr
);
  logic [EVT_N-1:0] pend, code_oh, below;
  logic rd_vec;
  assign pend    = flags & mask;
  assign code_oh = (code == '0) ? '0 : (EVT_N'(1) << (code - CODE_W'(1)));
  assign below   = code_oh - EVT_N'(1);
  assign rd_vec  = reg_rd && (reg_addr == A_VEC);

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt))); // R1
  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> (((pend & code_oh) != '0) && ((pend & below) == '0))); // R3
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (code == '0)); // R4
  AST_IRQ_TRACKS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != '0)); // R5
  AST_RDCLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && ((code_oh & RDCLR_SET) != '0) && ((evt & code_oh) == '0))
      |=> ((flags & $past(code_oh)) == '0)); // R6
  AST_STICKY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && ((code_oh & W1C_SET) != '0)) |=> ((flags & $past(code_oh)) != '0)); // R7
  AST_NONW1C_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT)
      |=> ((flags & $past(flags) & RDCLR_SET) == ($past(flags) & RDCLR_SET))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && ((evt & code_oh) != '0)) |=> ((flags & $past(code_oh)) != '0)); // R10
endmodule

bind serial_evt_vector sev_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .flags(flags_q), .mask(mask_q),
  .code(vec_code), .irq(irq), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr)
);

// File: tb/serial_evt_vector_tb.sv
module serial_evt_vector_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] evt_pulse = '0;
  logic bus_busy = 1'b0, rx_full = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [6:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  int n_tests = 0, n_fail = 0;
  bit [6:0] m_flags = '0;
  bit [6:0] m_mask  = 7'h67;

  always #10 clk = ~clk;

  serial_evt_vector u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_busy(bus_busy),
    .rx_full(rx_full), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic int m_code();
    bit [6:0] p = m_flags & m_mask;
    for (int i = 0; i < 7; i++) if (p[i]) return i + 1;
    return 0;
  endfunction

  function automatic bit [15:0] m_rdata();
    if (!reg_rd) return 16'h0;
    case (reg_addr)
      2'd0: return {9'h0, m_mask};
      2'd1: return {3'b0, bus_busy, rx_full, 4'h0, m_flags};
      2'd2: return 16'(m_code());
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, advance model after it
  task automatic step(bit [6:0] ev, bit wr, bit rd, bit [1:0] a, bit [6:0] wd,
                      string tag, int hard_exp = -1);
    bit [6:0] clr;
    int c;
    @(negedge clk);
    evt_pulse = ev; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    #1;
    c = m_code();
    check("R5 irq", int'(irq), int'(c != 0));
    check({tag, " rdata"}, int'(reg_rdata), int'(m_rdata()));
    if (hard_exp >= 0) check({tag, " value"}, int'(reg_rdata), hard_exp);
    @(posedge clk);
    clr = '0;
    if (wr && a == 2'd1) clr |= wd & 7'h24;
    if (rd && a == 2'd2 && c != 0 && c != 3 && c != 6) clr |= 7'(1 << (c - 1));
    if (wr && a == 2'd0) m_mask = wd;
    m_flags = (m_flags & ~clr) | ev;
  endtask

  task automatic rd(bit [1:0] a, string tag, int exp);
    step(7'h0, 1'b0, 1'b1, a, 7'h0, tag, exp);
  endtask

  task automatic wr(bit [1:0] a, bit [6:0] d, string tag);
    step(7'h0, 1'b1, 1'b0, a, d, tag);
  endtask

  task automatic pulse(bit [6:0] ev, string tag);
    step(ev, 1'b0, 1'b0, 2'd0, 7'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // reset state
    rd(2'd0, "R2 mask reset", 16'h0067);
    rd(2'd1, "R9 status reset", 16'h0000);
    rd(2'd2, "R3 vector idle", 0);
    rd(2'd3, "R11 unused addr", 0);
    step(7'h0, 1'b0, 1'b0, 2'd0, 7'h0, "R11 no read", 0);
    // three events at once, priority drain
    pulse(7'h07, "R1 pulse");
    rd(2'd1, "R1 status latched", 16'h0007);
    wr(2'd1, 7'h5B, "R8 write");
    rd(2'd1, "R8 non-w1c kept", 16'h0007);
    rd(2'd2, "R3 arb first", 1);
    rd(2'd2, "R6 nak next", 2);
    rd(2'd2, "R6 ardy next", 3);
    rd(2'd2, "R7 ardy sticky", 3);
    wr(2'd1, 7'h04, "R7 w1c ardy");
    rd(2'd2, "R7 cleared", 0);
    rd(2'd2, "R6 empty read", 0);
    // masked receive-ready
    pulse(7'h08, "R4 pulse");
    rd(2'd1, "R4 latched", 16'h0008);
    rd(2'd2, "R4 hidden", 0);
    wr(2'd0, 7'h7F, "R2 write mask");
    rd(2'd0, "R2 mask readback", 16'h007F);
    rd(2'd2, "R2 rrdy enabled", 4);
    rd(2'd2, "R6 rrdy cleared", 0);
    // transmit ready read-clear
    pulse(7'h10, "R1 xrdy");
    rd(2'd2, "R3 xrdy", 5);
    rd(2'd2, "R6 xrdy cleared", 0);
    // stop and target
    pulse(7'h60, "R1 stop tgt");
    rd(2'd2, "R3 stop over tgt", 6);
    rd(2'd2, "R7 stop sticky", 6);
    wr(2'd1, 7'h20, "R7 w1c stop");
    rd(2'd2, "R3 tgt", 7);
    rd(2'd2, "R6 tgt cleared", 0);
    // set wins over same-cycle clear
    pulse(7'h01, "R1 arb");
    step(7'h01, 1'b0, 1'b1, 2'd2, 7'h0, "R10 read with pulse", 1);
    rd(2'd2, "R10 flag kept", 1);
    rd(2'd2, "R6 arb cleared", 0);
    step(7'h04, 1'b1, 1'b0, 2'd1, 7'h04, "R10 w1c with pulse");
    rd(2'd2, "R10 ardy kept", 3);
    wr(2'd1, 7'h04, "R7 w1c");
    // level bits
    @(negedge clk); bus_busy = 1'b1; rx_full = 1'b1;
    rd(2'd1, "R9 levels", 16'h1800);
    @(negedge clk); bus_busy = 1'b0;
    rd(2'd1, "R9 rxfull only", 16'h0800);
    @(negedge clk); rx_full = 1'b0;
    step(7'h0, 1'b0, 1'b0, 2'd0, 7'h0, "R5 idle");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule